// File: doc/BRIEF.md
# Fractional reference clock generator

The block runs in a fast parent clock domain. It produces up to four reference clock enables from that one clock. Each channel emits single-cycle pulses on its own enable output. On average a channel fires at the parent rate times 18 divided by a 6-bit fraction value. A fraction of 18 gives the full parent rate. A fraction of 35 gives a little over half of it. The rate is not a 1/N division.

A modulo accumulator generates the pulses. Every parent cycle, an ungated channel adds 18 to its accumulator. When the sum reaches the active fraction, the channel subtracts the fraction and fires. A single 32-bit control word configures all four channels. Software reaches that word through a write port with three aliases: replace, OR-in and clear-bits. A fourth write address clears sticky range-error flags. The control word is always readable.

Top module: `frac_refclk_gen`

## Requirements
- R1: After reset the control word reads 0x92929292, every channel has fraction 18 and is gated, `err_o` is 0 and `ref_en_o` is 0.
- R2: Channel c owns byte c of the control word. Bits [8c+5:8c] hold its fraction and bit 8c+7 holds its gate. Bit 8c+6 always reads 0. A write to address 0 replaces the word, one cycle after the write edge.
- R3: A write to address 1 ORs the write data into the control word; bit 8c+6 stays 0.
- R4: A write to address 2 clears every control bit that is 1 in the write data.
- R5: While a channel's gate bit is 1, its enable stays low and its accumulator is held at zero. Ungating therefore restarts the channel from an empty accumulator.
- R6: From the edge that ungates channel c with fraction f, `ref_en_o[c]` is high on exactly floor(18k/f) of the next k cycles, counted from the cycle after that edge. With f = 18 the enable is high every cycle.
- R7: A fraction outside 18..35 (for example 0, 5, 40 or 63) is treated as 35.
- R8: `err_o[c]` is set one cycle after channel c's fraction field holds an out-of-range value. It then stays set until a write to address 3 with data bit c = 1. If the bad value is still present at that time, setting wins over clearing.
- R9: While a channel is running, a new fraction takes effect only at the next pulse (accumulator wrap); the pulse itself still uses the old fraction. While the channel is gated, a new value takes effect at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Parent (PLL-domain) clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 2 | 0 replace, 1 OR-in, 2 clear bits, 3 clear error flags |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Current control word |
| err_o | output | 4 | Sticky out-of-range flags, one per channel |
| ref_en_o | output | 4 | Per-channel single-cycle enable pulses |

## Verification
The bench counts pulses over windows that start at the ungating edge and compares each count with floor(18k/f). It does this at fractions 18, 24, 27 and 35. A design that lost the accumulator remainder, or did not reset the accumulator while gated, would be one pulse off. A fraction change timed just after a wrap separates deferred from immediate application: an immediate update would pulse one cycle early. Out-of-range fractions must run at the rate for 35 and raise a flag that survives a later fix of the field. The bench also checks that the unused bit in each byte can never be set by a replace or OR-in write.

// File: rtl/frac_refclk_pkg.sv
package frac_refclk_pkg;
  localparam int unsigned FRAC_W   = 6;
  localparam int unsigned ACC_W    = FRAC_W + 1;
  localparam int unsigned MUL      = 18;
  localparam int unsigned FRAC_MIN = 18;
  localparam int unsigned FRAC_MAX = 35;
  localparam int unsigned SLOT_W   = 8;
  localparam int unsigned GATE_BIT = 7;

  typedef enum logic [1:0] {
    WA_WORD   = 2'd0,
    WA_SET    = 2'd1,
    WA_CLR    = 2'd2,
    WA_ERRCLR = 2'd3
  } wr_addr_e;
endpackage

// File: rtl/frac_ctrl_regs.sv
module frac_ctrl_regs
  import frac_refclk_pkg::*;
#(
  parameter int unsigned NUM_CH   = 4,
  parameter int unsigned RST_FRAC = 18
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [1:0]                 wr_addr_i,
  input  logic [NUM_CH*SLOT_W-1:0]   wr_data_i,
  input  logic [NUM_CH-1:0]          oor_i,
  output logic [NUM_CH*SLOT_W-1:0]   ctrl_o,
  output logic [NUM_CH-1:0]          err_o
);
  localparam int unsigned WORD_W = NUM_CH * SLOT_W;

  function automatic logic [WORD_W-1:0] mk_live();
    logic [WORD_W-1:0] m;
    m = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      m[c*SLOT_W +: FRAC_W]   = '1;
      m[c*SLOT_W + GATE_BIT] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [WORD_W-1:0] mk_rst();
    logic [WORD_W-1:0] m;
    m = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      m[c*SLOT_W +: FRAC_W]   = FRAC_W'(RST_FRAC);
      m[c*SLOT_W + GATE_BIT] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [WORD_W-1:0] LIVE  = mk_live();
  localparam logic [WORD_W-1:0] RST_W = mk_rst();

  wr_addr_e                 addr;
  logic [WORD_W-1:0]        ctrl_q, ctrl_d;
  logic [NUM_CH-1:0]        err_q, err_d, clr_vec;

  assign addr = wr_addr_e'(wr_addr_i);

  always_comb begin
    ctrl_d  = ctrl_q;
    clr_vec = '0;
    if (wr_en_i) begin
      unique case (addr)
        WA_WORD:   ctrl_d  = wr_data_i & LIVE;
        WA_SET:    ctrl_d  = ctrl_q | (wr_data_i & LIVE);
        WA_CLR:    ctrl_d  = ctrl_q & ~wr_data_i;
        WA_ERRCLR: clr_vec = wr_data_i[NUM_CH-1:0];
        default:   ctrl_d  = ctrl_q;
      endcase
    end
    // set wins over clear
    err_d = (err_q & ~clr_vec) | oor_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= RST_W;
      err_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      err_q  <= err_d;
    end
  end

  assign ctrl_o = ctrl_q;
  assign err_o  = err_q;

  // R2
  word_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 2'd0) |=> ctrl_q == ($past(wr_data_i) & LIVE));
  // R3
  set_or_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 2'd1) |=>
      ctrl_q == ($past(ctrl_q) | ($past(wr_data_i) & LIVE)));
  // R4
  clr_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 2'd2) |=> (ctrl_q & $past(wr_data_i)) == '0);
  // R8
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(err_q) & ~$past(clr_vec) & ~err_q) == '0));
endmodule

// File: rtl/frac_chan.sv
module frac_chan
  import frac_refclk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic              gate_i,
  output logic              en_o,
  output logic              range_err_o
);
  localparam logic [ACC_W-1:0]  MUL_A = ACC_W'(MUL);
  localparam logic [FRAC_W-1:0] F_MIN = FRAC_W'(FRAC_MIN);
  localparam logic [FRAC_W-1:0] F_MAX = FRAC_W'(FRAC_MAX);

  logic              in_range, wrap, en_q;
  logic [FRAC_W-1:0] frac_eff, act_q;
  logic [ACC_W-1:0]  acc_q, sum;

  assign in_range    = (frac_i >= F_MIN) && (frac_i <= F_MAX);
  assign frac_eff    = in_range ? frac_i : F_MAX;
  assign range_err_o = !in_range;
  assign sum         = acc_q + MUL_A;
  assign wrap        = !gate_i && (sum >= {1'b0, act_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      act_q <= F_MIN;
      en_q  <= 1'b0;
    end else if (gate_i) begin
      acc_q <= '0;
      act_q <= frac_eff;
      en_q  <= 1'b0;
    end else if (wrap) begin
      acc_q <= sum - {1'b0, act_q};
      act_q <= frac_eff;  // new fraction only at wrap
      en_q  <= 1'b1;
    end else begin
      acc_q <= sum;
      en_q  <= 1'b0;
    end
  end

  assign en_o = en_q;

  // R5
  gate_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_i |=> (!en_o && acc_q == '0));
  // R7
  act_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q >= F_MIN) && (act_q <= F_MAX));
  // R9
  act_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_q) |-> ($past(gate_i) || en_o));
  // R6
  acc_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q < {1'b0, act_q});
endmodule

// File: rtl/frac_refclk_gen.sv
module frac_refclk_gen
  import frac_refclk_pkg::*;
#(
  parameter int unsigned NUM_CH   = 4,
  parameter int unsigned RST_FRAC = 18
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [1:0]               wr_addr_i,
  input  logic [NUM_CH*SLOT_W-1:0] wr_data_i,
  output logic [NUM_CH*SLOT_W-1:0] rd_data_o,
  output logic [NUM_CH-1:0]        err_o,
  output logic [NUM_CH-1:0]        ref_en_o
);
  logic [NUM_CH*SLOT_W-1:0] ctrl;
  logic [NUM_CH-1:0]        oor;

  frac_ctrl_regs #(
    .NUM_CH  (NUM_CH),
    .RST_FRAC(RST_FRAC)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .oor_i    (oor),
    .ctrl_o   (ctrl),
    .err_o    (err_o)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    frac_chan u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .frac_i     (ctrl[c*SLOT_W +: FRAC_W]),
      .gate_i     (ctrl[c*SLOT_W + GATE_BIT]),
      .en_o       (ref_en_o[c]),
      .range_err_o(oor[c])
    );
  end

  assign rd_data_o = ctrl;
endmodule

// File: tb/frac_refclk_gen_tb.sv
module frac_refclk_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [3:0]  err, ref_en;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  frac_refclk_gen dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .wr_en_i  (wr_en),
    .wr_addr_i(wr_addr),
    .wr_data_i(wr_data),
    .rd_data_o(rd_data),
    .err_o    (err),
    .ref_en_o (ref_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // returns at the negedge after the capturing edge
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic count(input int ch, input int k, output int n, output int other);
    n = 0; other = 0;
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      if (ref_en[ch]) n++;
      for (int j = 0; j < 4; j++) if (j != ch && ref_en[j]) other++;
    end
  endtask

  function automatic logic [31:0] word_with(input int ch, input logic [7:0] b);
    logic [31:0] w;
    w = 32'h9292_9292;
    w[ch*8 +: 8] = b;
    return w;
  endfunction

  task automatic t_reset();
    check("R1 word", rd_data, 32'h9292_9292);
    check("R1 err", {28'd0, err}, 32'd0);
    check("R1 en", {28'd0, ref_en}, 32'd0);
  endtask

  task automatic t_layout_err();
    wr(2'd0, 32'hFFFF_FFFF);
    check("R2 reserved bit", rd_data, 32'hBFBF_BFBF);
    wr(2'd0, 32'h9292_9292);
    check("R2 replace", rd_data, 32'h9292_9292);
    check("R8 sticky", {28'd0, err}, 32'hF);
    wr(2'd3, 32'h0000_0005);
    check("R8 partial clear", {28'd0, err}, 32'hA);
    wr(2'd3, 32'h0000_000F);
    check("R8 clear", {28'd0, err}, 32'h0);
  endtask

  task automatic t_set_clr();
    wr(2'd1, 32'h0000_0041);
    check("R3 set", rd_data, 32'h9292_9293);
    wr(2'd2, 32'h0000_8080);
    check("R4 clear", rd_data, 32'h9292_1213);
    wr(2'd0, 32'h9292_9292);
    check("R4 restore", rd_data, 32'h9292_9292);
  endtask

  task automatic t_rate(input int ch, input int f, input int k, input string tag);
    int n, o;
    wr(2'd0, word_with(ch, 8'h80 | 8'(f)));
    wr(2'd0, word_with(ch, 8'(f)));
    count(ch, k, n, o);
    check(tag, n, (18 * k) / (f < 18 || f > 35 ? 35 : f));
    check("R5 others gated", o, 0);
  endtask

  task automatic t_gate();
    int n, o;
    wr(2'd0, word_with(2, 8'd27));
    count(2, 10, n, o);
    wr(2'd0, 32'h9292_9292);
    count(2, 20, n, o);
    check("R5 gated quiet", n + o, 0);
    // restart from empty accumulator
    t_rate(2, 27, 54, "R5 restart");
  endtask

  task automatic t_clamp();
    t_rate(1, 5, 70, "R7 frac 5");
    check("R8 err set", {28'd0, err}, 32'h2);
    t_rate(3, 40, 70, "R7 frac 40");
    check("R8 err ch3", {28'd0, err}, 32'hA);
    wr(2'd0, 32'h9292_9292);
    wr(2'd3, 32'h0000_000F);
    check("R8 err cleared", {28'd0, err}, 32'h0);
  endtask

  task automatic t_defer();
    logic [4:0] s;
    wr(2'd0, 32'h9292_92A3);
    wr(2'd0, 32'h9292_9223);   // ungate ch0 f=35
    @(negedge clk);            // after E1
    s[0] = ref_en[0];
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 32'h9292_9212;
    @(negedge clk);            // after E2
    s[1] = ref_en[0];
    wr_en = 1'b0;
    for (int i = 2; i < 5; i++) begin
      @(negedge clk);
      s[i] = ref_en[0];
    end
    check("R9 deferred change", {27'd0, s}, {27'd0, 5'b11010});
    wr(2'd0, 32'h9292_9292);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_layout_err();
    t_set_clr();
    t_rate(0, 18, 50, "R6 frac 18");
    t_rate(1, 27, 54, "R6 frac 27");
    t_rate(0, 35, 70, "R6 frac 35");
    t_rate(2, 24, 48, "R6 frac 24");
    t_rate(3, 19, 38, "R6 frac 19");
    t_gate();
    t_clamp();
    t_defer();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule